// File: doc/BRIEF.md
# Pin Interrupt Configuration Unit

This block collects interrupt events from eight input pins of a power-management peripheral. It turns them into one request line toward an upstream arbiter. Each pin is first brought into the local clock domain by a synchroniser. A per-pin event detector then works in one of two modes. In edge mode it reacts to a rising edge, a falling edge or both. In level mode it reacts while the pin is high, or while it is low. Which mode applies comes from three configuration bits per pin: a mode bit and two polarity bits.

Software reaches the block through a byte-wide register port. Each write presents an address, a data byte and a one-cycle write strobe. Reads are combinational on the address. Enabling and disabling pins is done with write-one-to-set and write-one-to-clear addresses. The sticky latched events are cleared with a write-one-to-clear address. Software configures a pin by writing the mode, polarity-high and polarity-low registers at three consecutive offsets. The pin is then enabled, and the request output is served by reading and clearing the latched status.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset the mode, polarity-high, polarity-low, enable and latched registers all read 0x00, and `irq_o` is low.
- R2: The mode register sits at offset 0x11, polarity-high at 0x12 and polarity-low at 0x13. Each reads back the last byte written, and bit i of each belongs to pin i.
- R3: Offset 0x10 reads the synchronised pin levels, with bit i for pin i. A pin change made before a clock edge appears in that register after the second rising clock edge.
- R4: With mode bit 1 (edge), a 0-to-1 change of the pin latches an event when polarity-high is 1. A 1-to-0 change latches an event when polarity-low is 1. With both polarity bits set, either change latches.
- R5: With mode bit 0 (level), an event latches in every cycle that the pin is 1 with polarity-high set. It also latches in every cycle that the pin is 0 with polarity-low set.
- R6: Writing a byte to 0x15 sets the enable bits that are 1 in the byte. Writing a byte to 0x16 clears the enable bits that are 1 in the byte. Reading either 0x15 or 0x16 returns the enable mask.
- R7: An event on a pin whose enable bit is 0 leaves its latched bit unchanged.
- R8: Offset 0x18 reads the latched events. Writing a byte to 0x14 clears the latched bits that are 1 in the byte and leaves the others unchanged.
- R9: When an enabled event and a clear of the same latched bit fall in the same cycle, the bit stays set.
- R10: `irq_o` is high exactly when some pin has both its latched bit and its enable bit set. Clearing an enable bit masks the request but keeps the latched bit.
- R11: An enabled edge or level event caused by a pin change becomes visible in the latched status and on `irq_o` after the third rising clock edge following the change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw interrupt pins, asynchronous to clk |
| reg_wen | input | 1 | Register write strobe, one cycle per byte |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for the offset on reg_addr |
| irq_o | output | 1 | Interrupt request toward the arbiter |

## Verification
A write to the latched-clear offset and a fresh event on the same pin can land on the same clock edge. For a level-sensitive pin this is provoked by holding the pin in its active state while the clear is written. The latched bit must then read back as still set, and the request must stay high. The opposite outcome is also checked: an edge-mode pin with a quiet input, where the same clear must leave the bit at zero. A sweep over every pin and all eight mode and polarity combinations runs a full low, rise, clear and fall sequence on each. The expected latched vector after each step is built from the configuration bits alone.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFF_RT    = 8'h10;
  localparam logic [REG_AW-1:0] OFF_MODE  = 8'h11;
  localparam logic [REG_AW-1:0] OFF_PHI   = 8'h12;
  localparam logic [REG_AW-1:0] OFF_PLO   = 8'h13;
  localparam logic [REG_AW-1:0] OFF_LCLR  = 8'h14;
  localparam logic [REG_AW-1:0] OFF_ENSET = 8'h15;
  localparam logic [REG_AW-1:0] OFF_ENCLR = 8'h16;
  localparam logic [REG_AW-1:0] OFF_LSTS  = 8'h18;

  typedef enum logic [2:0] {
    WR_NONE, WR_MODE, WR_PHI, WR_PLO, WR_LCLR, WR_ENSET, WR_ENCLR
  } wr_kind_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pic_detect.sv
module pic_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] phi_i,
  input  logic [N-1:0] plo_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pin
      logic rise, fall, edge_hit, level_hit;
      assign rise      = lvl_i[i] & ~prev_q[i];
      assign fall      = ~lvl_i[i] & prev_q[i];
      assign edge_hit  = (phi_i[i] & rise) | (plo_i[i] & fall);
      assign level_hit = (phi_i[i] & lvl_i[i]) | (plo_i[i] & ~lvl_i[i]);
      assign evt_o[i]  = mode_i[i] ? edge_hit : level_hit;
    end
  endgenerate
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      rt_i,
  input  logic [N-1:0]      evt_i,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      phi_o,
  output logic [N-1:0]      plo_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      lat_o
);
  wr_kind_e     wk;
  logic [N-1:0] clr_mask;

  always_comb begin
    wk = WR_NONE;
    if (wen_i) begin
      case (addr_i)
        OFF_MODE:  wk = WR_MODE;
        OFF_PHI:   wk = WR_PHI;
        OFF_PLO:   wk = WR_PLO;
        OFF_LCLR:  wk = WR_LCLR;
        OFF_ENSET: wk = WR_ENSET;
        OFF_ENCLR: wk = WR_ENCLR;
        default:   wk = WR_NONE;
      endcase
    end
  end

  assign clr_mask = (wk == WR_LCLR) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0;
      phi_o  <= '0;
      plo_o  <= '0;
      en_o   <= '0;
    end else begin
      case (wk)
        WR_MODE:  mode_o <= wdata_i;
        WR_PHI:   phi_o  <= wdata_i;
        WR_PLO:   plo_o  <= wdata_i;
        WR_ENSET: en_o   <= en_o | wdata_i;
        WR_ENCLR: en_o   <= en_o & ~wdata_i;
        default:  ;
      endcase
    end
  end

  // Events are gated by the enable mask seen before this cycle's write,
  // and a fresh event outranks a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_o <= '0;
    else        lat_o <= (lat_o & ~clr_mask) | (evt_i & en_o);
  end

  always_comb begin
    case (addr_i)
      OFF_RT:    rdata_o = rt_i;
      OFF_MODE:  rdata_o = mode_o;
      OFF_PHI:   rdata_o = phi_o;
      OFF_PLO:   rdata_o = plo_o;
      OFF_ENSET: rdata_o = en_o;
      OFF_ENCLR: rdata_o = en_o;
      OFF_LSTS:  rdata_o = lat_o;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pic_pkg::*;
#(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pin_i,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  output logic              irq_o
);
  logic [N-1:0] rt_vec;
  logic [N-1:0] evt_vec;
  logic [N-1:0] mode_vec, phi_vec, plo_vec;
  logic [N-1:0] en_mask, lat_vec;

  pic_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(rt_vec)
  );

  pic_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl_i(rt_vec),
    .mode_i(mode_vec), .phi_i(phi_vec), .plo_i(plo_vec), .evt_o(evt_vec)
  );

  pic_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wen_i(reg_wen), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .rt_i(rt_vec), .evt_i(evt_vec),
    .mode_o(mode_vec), .phi_o(phi_vec), .plo_o(plo_vec),
    .en_o(en_mask), .lat_o(lat_vec)
  );

  assign irq_o = |(lat_vec & en_mask);
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      pin_i,
  input logic              reg_wen,
  input logic [REG_AW-1:0] reg_addr,
  input logic [N-1:0]      reg_wdata,
  input logic              irq_o,
  input logic [N-1:0]      rt_vec,
  input logic [N-1:0]      evt_vec,
  input logic [N-1:0]      en_mask,
  input logic [N-1:0]      lat_vec
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_rt_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (rt_vec == $past(pin_i, 2)));

  p_enable_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == OFF_ENSET) |=> ((en_mask & $past(reg_wdata)) == $past(reg_wdata)));

  p_enable_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == OFF_ENCLR) |=> ((en_mask & $past(reg_wdata)) == '0));

  p_latch_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((lat_vec & ~$past(lat_vec) & ~$past(en_mask)) == '0));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == OFF_LCLR) |=>
      ((lat_vec & $past(reg_wdata) & ~$past(evt_vec & en_mask)) == '0));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(evt_vec & en_mask) & ~lat_vec) == '0));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0) |-> !irq_o);
endmodule

bind pin_irq_unit pic_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wen(reg_wen),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_o(irq_o),
  .rt_vec(rt_vec), .evt_vec(evt_vec), .en_mask(en_mask), .lat_vec(lat_vec)
);

// File: tb/tb_pin_irq_unit.sv
module tb_pin_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       reg_wen = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  pin_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    #1;
    chk(tag, {7'd0, irq_o}, {7'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_rd("R1 mode", 8'h11, 8'h00);
    chk_rd("R1 phi", 8'h12, 8'h00);
    chk_rd("R1 plo", 8'h13, 8'h00);
    chk_rd("R1 enable", 8'h15, 8'h00);
    chk_rd("R1 latched", 8'h18, 8'h00);
    chk_irq("R1 irq", 1'b0);

    // Sweep: every pin, every mode/polarity combination
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic e, h, l;
        logic [7:0] b, ea, eb, ec, ed;
        e = c[2]; h = c[1]; l = c[0];
        b = 8'(1) << p;
        wr(8'h16, 8'hFF);
        wr(8'h14, 8'hFF);
        wr(8'h11, e ? b : 8'h00);
        wr(8'h12, h ? b : 8'h00);
        wr(8'h13, l ? b : 8'h00);
        chk_rd("R2 mode readback", 8'h11, e ? b : 8'h00);
        chk_rd("R2 phi readback", 8'h12, h ? b : 8'h00);
        chk_rd("R2 plo readback", 8'h13, l ? b : 8'h00);
        wr(8'h15, b);
        wr(8'h14, b);
        ea = (!e && l) ? b : 8'h00;
        chk_rd(e ? "R4 idle low" : "R5 held low", 8'h18, ea);
        chk_irq("R10 idle", ea != 0);
        // rising change
        pin_i[p] = 1'b1;
        tick(2);
        chk_rd("R3 rt high", 8'h10, b);
        chk_rd("R11 not yet latched", 8'h18, ea);
        tick(1);
        eb = ea | (h ? b : 8'h00);
        chk_rd(e ? "R4 rising" : "R5 high level", 8'h18, eb);
        chk_irq("R10 after rise", eb != 0);
        // clear while pin high
        wr(8'h14, b);
        ec = (!e && h) ? b : 8'h00;
        chk_rd(ec != 0 ? "R9 event beats clear" : "R8 clear", 8'h18, ec);
        chk_irq("R9 irq after clear", ec != 0);
        // falling change
        pin_i[p] = 1'b0;
        tick(3);
        ed = ec | (l ? b : 8'h00);
        chk_rd(e ? "R4 falling" : "R5 low level", 8'h18, ed);
        chk_rd("R3 rt low", 8'h10, 8'h00);
      end
    end

    // R7: disabled pins do not latch
    wr(8'h16, 8'hFF);
    wr(8'h14, 8'hFF);
    wr(8'h11, 8'hFF);
    wr(8'h12, 8'hFF);
    wr(8'h13, 8'h00);
    pin_i = 8'hFF;
    tick(4);
    chk_rd("R7 disabled latched", 8'h18, 8'h00);
    chk_irq("R7 disabled irq", 1'b0);
    pin_i = 8'h00;
    tick(4);

    // R6: set/clear enable and read back at both offsets
    wr(8'h15, 8'h5A);
    chk_rd("R6 enset read", 8'h15, 8'h5A);
    chk_rd("R6 enclr read", 8'h16, 8'h5A);
    wr(8'h16, 8'h12);
    chk_rd("R6 after clear", 8'h15, 8'h48);
    chk_rd("R6 after clear alt", 8'h16, 8'h48);

    // R10 / R8: multi-pin OR, masking, partial clear
    pin_i = 8'h49;
    tick(3);
    chk_rd("R7 pin0 disabled", 8'h18, 8'h48);
    chk_irq("R10 two pins", 1'b1);
    pin_i = 8'h00;
    tick(3);
    wr(8'h16, 8'h48);
    chk_irq("R10 masked", 1'b0);
    chk_rd("R10 latch kept", 8'h18, 8'h48);
    wr(8'h15, 8'h08);
    chk_irq("R10 unmasked", 1'b1);
    wr(8'h14, 8'h08);
    chk_rd("R8 partial clear", 8'h18, 8'h40);
    chk_irq("R10 only masked left", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule